// File: doc/BRIEF.md
# Digitally Controlled Oscillator Tuning Core

This block models the tuning path of a digitally controlled oscillator. It holds an 8-bit stage word and a 4-bit divider exponent, and it accepts signed correction steps from a loop filter. A step is either fine (one unit at bit 0) or coarse (one unit at bit 5). The stage word can only change the exponent through its own carry or borrow.

A reference tick input stands in for one stage delay of the ring. The ring output toggles once every 17 + 2·N ticks, where N is the top three bits of the stage word. That ring output is then divided by 2^exponent to give the output clock. The control words that drive the timing are copied from the live words only when a full output period ends. Because of this, a correction never shortens or stretches the output period that is already running.

Top module: `dco_tune_core`

## Requirements
- R1: After reset the stage word reads 0x00, the exponent reads 0 and `clk_o` is low.
- R2: One period of `clk_o` lasts (17 + 2·N)·2·2^E reference ticks. N is `stage_o[7:5]` and E is `expo_o`. Bits 4:0 of the stage word do not change the period.
- R3: Only cycles with `tick_i` high advance the timing, so cycles with `tick_i` low do not change the period measured in ticks.
- R4: A step with `step_valid_i` high changes the stage word by one unit in the cycle after it. `step_coarse_i` = 0 selects a unit of 1 and `step_coarse_i` = 1 selects a unit of 32. `step_up_i` = 1 adds the unit and `step_up_i` = 0 subtracts it.
- R5: An addition that carries out of bit 7 raises the exponent by one and lets the stage word wrap modulo 256. A subtraction that borrows lowers the exponent by one and also wraps the stage word.
- R6: The exponent never exceeds 9. A carry while the exponent is 9 leaves it at 9 and sets the stage word to 0xFF.
- R7: A borrow while the exponent is 0 leaves it at 0 and sets the stage word to 0x00.
- R8: Periods are measured from one falling edge of `clk_o` to the next. A step taken during a period leaves that period's length unchanged. The new length applies from the following period.
- R9: For a given change of N, the ratio between the old and new periods is the same at every exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One reference tick (one stage delay) when high |
| step_valid_i | input | 1 | Apply one correction step this cycle |
| step_up_i | input | 1 | 1 adds the step, 0 subtracts it |
| step_coarse_i | input | 1 | 1 selects a unit of 32, 0 selects a unit of 1 |
| clk_o | output | 1 | Divided output clock |
| stage_o | output | 8 | Live stage word |
| expo_o | output | 4 | Live divider exponent |

## Verification
The period is first measured with a tick on every cycle and then with a tick on every other cycle. This separates counting ticks from counting clock cycles. The bench drives fine steps that touch only the low stage bits and coarse steps that move N, and it does this at exponents 0, 1 and 9. These runs show that low bits have no effect on the period, that N scales the period, and that the exponent doubles it. A step issued just after a falling edge shows whether the period in progress keeps its old length. Long runs of coarse steps, both upward and downward, reach the carry, borrow and saturation corners.

// File: rtl/dco_tune_pkg.sv
// Shared constants and the control-word type for the oscillator tuning core.
package dco_tune_pkg;
    localparam int STAGE_W     = 8;   // stage word width
    localparam int EXP_W       = 4;   // exponent code width
    localparam int EXP_MAX     = 9;   // highest usable exponent
    localparam int SEL_W       = 3;   // top stage bits selecting ring length
    localparam int BASE_DELAYS = 17;  // ring length at selector 0
    localparam int COARSE_BIT  = 5;   // bit weight of a coarse step
    localparam int LEN_W       = $clog2(BASE_DELAYS + 2 * ((1 << SEL_W) - 1) + 1);
    localparam int HALF_W      = EXP_MAX + 1;

    typedef struct packed {
        logic [STAGE_W-1:0] stage;
        logic [EXP_W-1:0]   expo;
    } ctrl_t;
endpackage

// File: rtl/dco_ctrl_word.sv
// Live control word. It applies fine or coarse steps to the stage word. A carry
// or borrow out of the stage word moves the exponent, which saturates at
// 0 and EXP_MAX. At saturation the stage word clamps instead of wrapping.
// Assumes at most one step per cycle.
module dco_ctrl_word
    import dco_tune_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step_valid,
    input  logic  step_up,
    input  logic  step_coarse,
    output ctrl_t word
);
    logic [STAGE_W:0]   unit_w;
    logic [STAGE_W:0]   sum_w;
    logic [STAGE_W:0]   dif_w;
    ctrl_t              nxt;

    // Compute the next control word from the requested step.
    always_comb begin
        unit_w = step_coarse ? (STAGE_W+1)'(1 << COARSE_BIT) : (STAGE_W+1)'(1);
        sum_w  = {1'b0, word.stage} + unit_w;
        dif_w  = {1'b0, word.stage} - unit_w;
        nxt    = word;
        if (step_valid) begin
            if (step_up) begin
                if (!sum_w[STAGE_W]) begin
                    nxt.stage = sum_w[STAGE_W-1:0];
                end else if (word.expo < EXP_W'(EXP_MAX)) begin
                    nxt.stage = sum_w[STAGE_W-1:0];
                    nxt.expo  = word.expo + 1'b1;
                end else begin
                    nxt.stage = '1;
                end
            end else begin
                if (!dif_w[STAGE_W]) begin
                    nxt.stage = dif_w[STAGE_W-1:0];
                end else if (word.expo != '0) begin
                    nxt.stage = dif_w[STAGE_W-1:0];
                    nxt.expo  = word.expo - 1'b1;
                end else begin
                    nxt.stage = '0;
                end
            end
        end
    end

    // Register the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) word <= '0;
        else        word <= nxt;
    end

    a_r6_exp_cap: assert property (@(posedge clk) disable iff (!rst_n)
        word.expo <= EXP_W'(EXP_MAX));
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> $stable(word));
    a_r5_exp_only_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        (word.expo != $past(word.expo)) |-> $past(step_valid));
endmodule

// File: rtl/dco_ring_timer.sv
// Ring stand-in. It counts reference ticks and pulses half_done when
// BASE_DELAYS + 2*sel ticks have passed, which is one ring half period.
// Assumes sel changes only on a cycle where half_done was high.
module dco_ring_timer
    import dco_tune_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             half_done
);
    logic [LEN_W-1:0] len_w;
    logic [LEN_W-1:0] cnt_q;

    // Derive the ring length and the end-of-half strobe.
    always_comb begin
        len_w     = LEN_W'(BASE_DELAYS) + LEN_W'({sel, 1'b0});
        half_done = tick && (cnt_q == len_w - 1'b1);
    end

    // Count ticks within one ring half period.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (half_done) cnt_q <= '0;
        else if (tick)      cnt_q <= cnt_q + 1'b1;
    end

    a_r2_ring_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < len_w);
    a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
endmodule

// File: rtl/dco_pow2_div.sv
// Power-of-two divider. It toggles the output every 2^E ring half periods.
// Exponent codes above EXP_MAX are treated as EXP_MAX. period_end marks the
// falling edge of the output, where the next control values may be taken.
module dco_pow2_div
    import dco_tune_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_done,
    input  logic [EXP_W-1:0] expo,
    output logic             clk_out,
    output logic             period_end
);
    logic [EXP_W-1:0]  eff_w;
    logic [HALF_W-1:0] lim_w;
    logic [HALF_W-1:0] cnt_q;
    logic              flip_w;

    // Clamp the exponent and find the last ring half of an output half.
    always_comb begin
        eff_w      = (expo > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : expo;
        lim_w      = (HALF_W'(1) << eff_w) - 1'b1;
        flip_w     = half_done && (cnt_q == lim_w);
        period_end = flip_w && clk_out;
    end

    // Count ring halves and toggle the output clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            clk_out <= 1'b0;
        end else if (flip_w) begin
            cnt_q   <= '0;
            clk_out <= ~clk_out;
        end else if (half_done) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    a_r2_div_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_w);
    a_r8_edge_only_on_flip: assert property (@(posedge clk) disable iff (!rst_n)
        !flip_w |=> $stable(clk_out));
endmodule

// File: rtl/dco_tune_core.sv
// Top of the tuning core. It reports the live control word. The word that
// drives the timing is copied from the live word only at the end of a full
// output period, so the output never shows a shortened or stretched pulse.
module dco_tune_core
    import dco_tune_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               step_valid_i,
    input  logic               step_up_i,
    input  logic               step_coarse_i,
    output logic               clk_o,
    output logic [STAGE_W-1:0] stage_o,
    output logic [EXP_W-1:0]   expo_o
);
    ctrl_t live_w;
    ctrl_t act_q;
    logic  half_w;
    logic  pend_w;

    dco_ctrl_word u_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_valid  (step_valid_i),
        .step_up     (step_up_i),
        .step_coarse (step_coarse_i),
        .word        (live_w)
    );

    dco_ring_timer u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_i),
        .sel       (act_q.stage[STAGE_W-1 -: SEL_W]),
        .half_done (half_w)
    );

    dco_pow2_div u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_done  (half_w),
        .expo       (act_q.expo),
        .clk_out    (clk_o),
        .period_end (pend_w)
    );

    // Take the live control word into the timing path at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= '0;
        else if (pend_w) act_q <= live_w;
    end

    assign stage_o = live_w.stage;
    assign expo_o  = live_w.expo;

    a_r8_applied_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_w |=> $stable(act_q));
    a_r8_period_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        pend_w |=> $fell(clk_o));
endmodule

// File: tb/dco_tune_core_tb_top.sv
module dco_tune_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       step_valid_i = 1'b0;
    logic       step_up_i = 1'b0;
    logic       step_coarse_i = 1'b0;
    logic       clk_o;
    logic [7:0] stage_o;
    logic [3:0] expo_o;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc = 0;
    int  acc = 0;
    int  last_per = 0;
    int  per_cnt = 0;
    bit  tick_gap = 1'b0;
    bit  phase = 1'b0;
    logic prev_o = 1'b0;

    always #5 clk = ~clk;

    dco_tune_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .step_valid_i(step_valid_i), .step_up_i(step_up_i),
        .step_coarse_i(step_coarse_i),
        .clk_o(clk_o), .stage_o(stage_o), .expo_o(expo_o)
    );

    // Drive ticks and measure tick counts between falling edges of clk_o.
    always @(negedge clk) begin
        if (!rst_n) begin
            acc = 0; per_cnt = 0; prev_o = 1'b0; tick_i = 1'b0;
        end else begin
            if (prev_o && !clk_o) begin
                last_per = acc; acc = 0; per_cnt++;
            end
            prev_o = clk_o;
            phase  = ~phase;
            tick_i = tick_gap ? phase : 1'b1;
            acc   += int'(tick_i);
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int exp_per(int stage, int e);
        int ee = (e > 9) ? 9 : e;
        return (17 + 2 * (stage >> 5)) * 2 * (1 << ee);
    endfunction

    task automatic check(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wait_falls(int k);
        int n0 = per_cnt;
        while (per_cnt < n0 + k) @(posedge clk);
    endtask

    task automatic step(bit up, bit coarse);
        @(negedge clk);
        step_valid_i = 1'b1; step_up_i = up; step_coarse_i = coarse;
        @(negedge clk);
        step_valid_i = 1'b0;
    endtask

    task automatic check_words(string req, int st, int e);
        check({req, " stage"}, int'(stage_o), st);
        check({req, " expo"}, int'(expo_o), e);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 clk_o", int'(clk_o), 0);
        check_words("R1", 0, 0);
    endtask

    task automatic t_floor();
        step(1'b0, 1'b0);
        check_words("R7 fine down at floor", 0, 0);
        step(1'b0, 1'b1);
        check_words("R7 coarse down at floor", 0, 0);
    endtask

    task automatic t_base();
        wait_falls(2);
        check("R2 base period", last_per, exp_per(0, 0));
        tick_gap = 1'b1;
        wait_falls(2);
        check("R3 gapped ticks period", last_per, exp_per(0, 0));
        tick_gap = 1'b0;
    endtask

    task automatic t_fine();
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        check_words("R4 fine up", 3, 0);
        wait_falls(2);
        check("R2 low bits ignored", last_per, exp_per(3, 0));
    endtask

    task automatic t_latch();
        wait_falls(1);
        step(1'b1, 1'b1);
        check_words("R4 coarse up", 8'h23, 0);
        wait_falls(1);
        check("R8 period in progress kept", last_per, exp_per(0, 0));
        wait_falls(1);
        check("R2 new N applied", last_per, exp_per(8'h23, 0));
    endtask

    task automatic t_carry();
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1);
        check_words("R4 coarse to top", 8'hE3, 0);
        wait_falls(2);
        check("R2 N=7 period", last_per, exp_per(8'hE3, 0));
        step(1'b1, 1'b1);
        check_words("R5 carry", 8'h03, 1);
        wait_falls(2);
        check("R5 exponent doubles", last_per, exp_per(8'h03, 1));
        step(1'b1, 1'b1);
        wait_falls(2);
        check("R9 N step at E=1", last_per, exp_per(8'h23, 1));
        check("R9 ratio matches E=0", last_per * exp_per(0, 0), 68 * exp_per(8'h23, 0));
    endtask

    task automatic t_borrow();
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check_words("R5 borrow", 8'hE3, 0);
        wait_falls(2);
        check("R5 exponent halves", last_per, exp_per(8'hE3, 0));
    endtask

    task automatic t_ceiling();
        for (int i = 0; i < 72; i++) step(1'b1, 1'b1);
        check_words("R6 reach E=9", 8'hE3, 9);
        step(1'b1, 1'b1);
        check_words("R6 saturate", 8'hFF, 9);
        step(1'b1, 1'b0);
        check_words("R6 held at ceiling", 8'hFF, 9);
        wait_falls(2);
        check("R6 period at E=9", last_per, exp_per(8'hFF, 9));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_floor();
        t_base();
        t_fine();
        t_latch();
        t_carry();
        t_borrow();
        t_ceiling();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule